// File: doc/BRIEF.md
# Prescaled Contrast PWM Generator

This block produces a pulse-width modulated level for setting display contrast or backlight brightness. A power-of-two prescaler slows the input clock, and each prescaler tick advances an 8-bit period counter. The output is active while that counter is below a programmed duty value. A polarity bit chooses whether active means high or low. An enable bit turns the waveform on and off. While the block is off, the output sits at the inactive level for the selected polarity.

Software reaches the block through a two-location register port: a write strobe with address and data, and a combinational read. A new duty value is first held as pending. It reaches the comparator only when the period counter wraps, so no period is ever cut short. Writing a duty of zero also clears the control register, which switches the output off.

Top module: `lumen_pwm`

## Requirements
- R1: After reset, the control location (address 0) reads 0x0B: divide by 8, not inverted, enabled. The duty location (address 1) reads 0xC8.
- R2: The control location holds the prescale select in bits [1:0], the invert flag in bit 2 and the enable flag in bit 3. Bits [7:4] ignore writes and read as zero. The duty location reads back the last value written to it.
- R3: Prescale select s gives a period of 256 × 2^s clock cycles (s = 0..3 gives divide by 1, 2, 4 and 8).
- R4: With invert clear, the output is high for duty × 2^s cycles of each period and low for the rest.
- R5: With invert set, the output is the complement of the R4 waveform.
- R6: While enable is clear, the output is held low if invert is clear and high if invert is set. On enable, the period restarts from count zero, so the output turns active on the second clock edge and, at divide by 1, stays active for exactly duty cycles.
- R7: A write of 0 to the duty location clears the whole control register to 0, so the output is held low.
- R8: A duty value written mid-period does not change the current period. It takes effect from the next counter wrap.
- R9: A duty of 0xFF gives 255 active steps and 1 inactive step per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pwm_out | output | 1 | PWM output after polarity |

## Verification
The bench builds the block with its default parameters: an 8-bit period counter and a 2-bit prescale select. With these values, full periods at every divide ratio last at most 2048 cycles. The bench can therefore measure whole-period high-time sums at divide by 1, 2, 4 and 8 with both polarities. It can also time single active runs at divide by 1, which exposes the restart on enable and the deferred duty update cycle by cycle.

// File: rtl/lumen_pwm_pkg.sv
// Shared layout of the control register for the contrast PWM.
package lumen_pwm_pkg;
    localparam int PSEL_W = 2;

    // Control fields, LSB first: prescale select, invert, enable.
    typedef struct packed {
        logic              en;
        logic              inv;
        logic [PSEL_W-1:0] sel;
    } pwm_ctrl_t;

    localparam int CTRL_W = $bits(pwm_ctrl_t);
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DUTY = 1'b1;
endpackage

// File: rtl/lumen_pwm_regs.sv
// Register file: control and duty, write strobe, combinational readback.
// Assumes a single-cycle write strobe; a duty write of zero clears control.
module lumen_pwm_regs
    import lumen_pwm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter logic [DUTY_W-1:0] DUTY_RST = 8'hC8,
    parameter logic [CTRL_W-1:0] CTRL_RST = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [DUTY_W-1:0] wdata,
    output logic [DUTY_W-1:0] rdata,
    output pwm_ctrl_t         ctrl,
    output logic [DUTY_W-1:0] duty
);
    // Update stored registers on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= pwm_ctrl_t'(CTRL_RST);
            duty <= DUTY_RST;
        end else if (wr) begin
            if (addr == ADDR_CTRL) begin
                ctrl <= pwm_ctrl_t'(wdata[CTRL_W-1:0]);
            end else begin
                duty <= wdata;
                if (wdata == '0) ctrl <= '0;
            end
        end
    end

    // Select readback data, unused control bits as zero.
    always_comb begin
        rdata = (addr == ADDR_DUTY) ? duty : DUTY_W'(ctrl);
    end

    assert_zero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_DUTY && wdata == '0) |=> (ctrl == '0 && duty == '0));

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CTRL) |=> (DUTY_W'(ctrl) == (DUTY_W'($past(wdata)) & DUTY_W'({CTRL_W{1'b1}}))));
endmodule

// File: rtl/lumen_pwm_tick.sv
// Power-of-two prescaler: emits one tick every 2^sel cycles while running.
// Assumes sel changes are tolerated mid-count; restarts from zero when stopped.
module lumen_pwm_tick #(
    parameter int PSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);
    localparam int PRE_W = (1 << PSEL_W) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    // Build mask of the low sel bits.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sel));
    end

    // Free-running divider count, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre <= '0;
        else                pre <= pre + 1'b1;
    end

    // Tick when all masked bits are set.
    always_comb begin
        tick = run && ((pre & mask) == mask);
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && sel != '0) |=> (!tick || !$stable(sel)));

    assert_tick_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: rtl/lumen_pwm_core.sv
// Period counter, duty shadow and output stage with polarity.
// Assumes tick is a one-cycle enable; duty shadow reloads at wrap or while off.
module lumen_pwm_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             inv,
    input  logic             tick,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] duty_rst,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] live;
    logic             wrap;

    // Last step of the period.
    always_comb wrap = tick && (cnt == CNT_MAX);

    // Period counter, advanced per tick, restarted while off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end

    // Duty shadow: follows pending value while off, reloads at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)            live <= duty_rst;
        else if (!run || wrap) live <= duty;
    end

    // Registered output with polarity and idle level.
    always_ff @(posedge clk) begin
        if (!rst_n)   pwm <= 1'b0;
        else if (run) pwm <= (cnt < live) ^ inv;
        else          pwm <= inv;
    end

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm == $past(inv)));

    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap) |=> (cnt == '0));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(live));
endmodule

// File: rtl/lumen_pwm.sv
// Top of the prescaled contrast PWM: registers, prescaler and core.
// Assumes one clock domain and a synchronous active-low reset.
module lumen_pwm
    import lumen_pwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] DUTY_RST = 8'hC8,
    parameter logic [CTRL_W-1:0] CTRL_RST = 4'hB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             pwm_out
);
    pwm_ctrl_t        ctrl;
    logic [CNT_W-1:0] duty;
    logic             tick;

    lumen_pwm_regs #(
        .DUTY_W(CNT_W), .DUTY_RST(DUTY_RST), .CTRL_RST(CTRL_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .duty(duty)
    );

    lumen_pwm_tick #(.PSEL_W(PSEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(ctrl.en), .sel(ctrl.sel), .tick(tick)
    );

    lumen_pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(ctrl.en), .inv(ctrl.inv),
        .tick(tick), .duty(duty), .duty_rst(DUTY_RST), .pwm(pwm_out)
    );
endmodule

// File: tb/lumen_pwm_bench.sv
module lumen_pwm_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lumen_pwm u_lumen_pwm (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    // Count high cycles over n cycles, sampled at negedge.
    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    // Wait for a rising edge, then return the length of the high run.
    task automatic high_run(output int len);
        len = 0;
        while (pwm_out !== 1'b0) @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        while (pwm_out === 1'b1) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int v;
        rd_reg(1'b0, v); check("R1 ctrl", v, 8'h0B);
        rd_reg(1'b1, v); check("R1 duty", v, 8'hC8);
    endtask

    task automatic t_readback;
        int v;
        wr_reg(1'b0, 8'hF6);
        rd_reg(1'b0, v); check("R2 ctrl upper bits dropped", v, 8'h06);
        wr_reg(1'b1, 8'h5A);
        rd_reg(1'b1, v); check("R2 duty readback", v, 8'h5A);
    endtask

    // Whole-period high count for a duty, select and polarity (R3 R4 R5).
    task automatic t_avg(input int duty, input int sel, input bit inv, input string req);
        int h, per, exp;
        per = 256 << sel;
        wr_reg(1'b1, 8'(duty));
        wr_reg(1'b0, 8'(32'h8 | (int'(inv) << 2) | sel));
        repeat (per + 8) @(negedge clk);
        count_high(2 * per, h);
        exp = 2 * duty * (1 << sel);
        if (inv) exp = 2 * per - exp;
        check(req, h, exp);
    endtask

    task automatic t_disable;
        int h;
        wr_reg(1'b0, 8'h04);
        repeat (2) @(negedge clk);
        count_high(300, h); check("R6 idle high when inverted", h, 300);
        wr_reg(1'b0, 8'h00);
        repeat (2) @(negedge clk);
        count_high(300, h); check("R6 idle low when not inverted", h, 0);
    endtask

    task automatic t_restart;
        int len;
        wr_reg(1'b1, 8'd100);
        wr_reg(1'b0, 8'h00);
        repeat (3) @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h08;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R6 inactive one edge after enable", int'(pwm_out), 0);
        len = 0;
        @(negedge clk);
        check("R6 active on second edge after enable", int'(pwm_out), 1);
        while (pwm_out === 1'b1) begin
            len++;
            @(negedge clk);
        end
        check("R6 first run after enable", len, 100);
    endtask

    task automatic t_zero;
        int v, h;
        wr_reg(1'b0, 8'h0A);
        wr_reg(1'b1, 8'h00);
        rd_reg(1'b0, v); check("R7 ctrl cleared", v, 0);
        rd_reg(1'b1, v); check("R7 duty zero", v, 0);
        count_high(300, h); check("R7 output held low", h, 0);
    endtask

    task automatic t_full;
        int len;
        wr_reg(1'b1, 8'hFF);
        wr_reg(1'b0, 8'h08);
        repeat (260) @(negedge clk);
        high_run(len); check("R9 run length at 0xFF", len, 255);
    endtask

    task automatic t_wrap_update;
        int len;
        wr_reg(1'b1, 8'd100);
        wr_reg(1'b0, 8'h08);
        repeat (260) @(negedge clk);
        while (pwm_out !== 1'b0) @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        len = 0;
        while (pwm_out === 1'b1) begin
            len++;
            if (len == 10) begin
                reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'd50;
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        check("R8 current period keeps old duty", len, 100);
        high_run(len); check("R8 next period uses new duty", len, 50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_avg(200, 3, 1'b0, "R4 div8 duty 200");
        t_avg(64, 0, 1'b0, "R3 div1 duty 64");
        t_avg(37, 1, 1'b0, "R3 div2 duty 37");
        t_avg(128, 2, 1'b1, "R5 div4 inverted");
        t_avg(10, 0, 1'b1, "R5 div1 inverted");
        t_disable();
        t_restart();
        t_zero();
        t_full();
        t_wrap_update();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule